// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is the serial engine of a full-duplex SPI master. A single start strobe loads one byte for transmission. The block then lowers the active-low slave select and produces eight serial clock periods. On each period it shifts one bit out on MOSI and samples one bit from MISO. When the transfer ends, the received byte appears on a parallel output and a completion flag is raised. The flag can drive an interrupt through an enable input.

The integrating logic sets the serial format through static configuration inputs:
- bit order, either most-significant bit first or least-significant bit first;
- serial clock idle level (polarity);
- which clock edge samples the data (phase);
- a two-bit rate field that divides the system clock by 4, 16, 64 or 128.

These inputs are expected to stay constant while a transfer is running. A global enable gates new transfers, and dropping it abandons a transfer that is in progress.

Top module: `spi_shift_master`

## Requirements
- R1: With `enable` high and `busy` low, a one-cycle `start` is accepted at the clock edge. From the next cycle, `busy` is high and `ss_n` is low, and `ss_n` stays low until `busy` falls.
- R2: Whenever `busy` is low, `sck` equals `cfg_cpol`. A transfer makes exactly 16 `sck` edges. The first edge comes D/2 system clocks after `ss_n` falls, and each later edge comes D/2 clocks after the one before. `busy` stays high for 17·D/2 cycles. `cfg_rate` 00, 01, 10 and 11 give D = 4, 16, 64 and 128.
- R3: One transfer sends all eight bits of `tx_byte` (captured at the accepted start) on `mosi`. In the same transfer it assembles eight bits from `miso` into `rx_byte`, which changes only when a transfer completes.
- R4: With `cfg_lsb_first` = 0, bit 7 is sent and received first. With `cfg_lsb_first` = 1, bit 0 goes first.
- R5: A leading edge is an `sck` transition away from the idle level, and a trailing edge is the transition back to it. With `cfg_cpha` = 0, the first bit is on `mosi` from the cycle `ss_n` falls, `miso` is sampled on leading edges, and `mosi` changes only on trailing edges. With `cfg_cpha` = 1, `mosi` changes only on leading edges and `miso` is sampled on trailing edges.
- R6: `done` rises in the cycle that `busy` falls after a full transfer, together with the new `rx_byte`. It then holds until `done_clr` is pulsed or the next start is accepted; the accepted start clears it.
- R7: `irq` is high exactly when `done` is high and `irq_en` is high.
- R8: A `start` that arrives while `busy` is high is ignored: the transmitted bits and the transfer length are unchanged.
- R9: With `enable` low, `start` is ignored. If `enable` falls during a transfer, then from the next cycle `busy` is low, `ss_n` is high and `sck` is at its idle level. In that case `done` stays low and `rx_byte` keeps its previous value.
- R10: After reset, `busy`, `done` and `irq` are 0, `ss_n` is 1, `rx_byte` is 0 and `sck` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Global enable; low blocks or abandons transfers |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_rate | input | 2 | Clock divisor select: 4, 16, 64, 128 |
| irq_en | input | 1 | Gates `done` onto `irq` |
| start | input | 1 | Begin a transfer |
| tx_byte | input | 8 | Byte to transmit, captured at an accepted start |
| done_clr | input | 1 | Clears the completion flag |
| miso | input | 1 | Serial data from the slave |
| rx_byte | output | 8 | Byte received in the last completed transfer |
| done | output | 1 | Transfer-complete flag |
| irq | output | 1 | Gated completion interrupt |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
The hardest case to reach is the combination of clock phase and bit order at a given divisor. Errors in that case show up only as one bit shifted by one edge or sampled on the wrong edge. The bench models a slave that reacts to each `sck` edge at the pins. For every mode and every divisor, it drives MISO bits on the edges where a slave would shift, records MOSI on the edges where a slave would sample, and times each half period. It also flags any MOSI change that falls on a sample edge. A start issued five cycles into a transfer and an enable dropped halfway through a byte reach the ignore and abandon paths.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned HALF_MAX = 64;
  localparam int unsigned HALF_W   = $clog2(HALF_MAX);

  typedef enum logic [1:0] {
    RATE_DIV4   = 2'b00,
    RATE_DIV16  = 2'b01,
    RATE_DIV64  = 2'b10,
    RATE_DIV128 = 2'b11
  } rate_e;

  // last count value of one SCK half period (half period minus one)
  function automatic logic [HALF_W-1:0] half_last(input rate_e sel);
    logic [HALF_W-1:0] v;
    case (sel)
      RATE_DIV4:   v = HALF_W'(1);
      RATE_DIV16:  v = HALF_W'(7);
      RATE_DIV64:  v = HALF_W'(31);
      default:     v = HALF_W'(HALF_MAX - 1);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/spim_rate_gen.sv
module spim_rate_gen
  import spim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  output logic  tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last  = half_last(rate);
    tick  = run && (cnt_q == last);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // half period never exceeds the selected divisor (R2)
  p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsb_first,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)
      tx_d = load_data;
    else if (shift_en)
      tx_d = lsb_first ? {1'b0, tx_q[DATA_W-1:1]} : {tx_q[DATA_W-2:0], 1'b0};

    rx_d = rx_q;
    if (sample_en)
      rx_d = lsb_first ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
  assign rx_data = rx_q;

  // serial output moves only on a shift edge or a load (R5)
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> (mosi == $past(mosi)) || (lsb_first != $past(lsb_first)));
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spim_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_rate,
  input  logic              irq_en,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              done_clr,
  input  logic              miso,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              irq,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EW    = $clog2(EDGES + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic          busy_q, busy_d;
  logic          phase_q, phase_d;
  logic          done_q, done_d;
  logic [EW-1:0] edge_q, edge_d;
  logic [DATA_W-1:0] rxb_q, rxb_d, rx_sh;
  logic tick, accept, abort, finish, step, lead, sample_en, shift_en;

  spim_rate_gen u_rate (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (busy_q),
    .rate  (rate_e'(cfg_rate)),
    .tick  (tick)
  );

  always_comb begin
    accept    = enable && start && !busy_q;
    abort     = busy_q && !enable;
    finish    = tick && (edge_q == LAST_EDGE) && !abort;
    step      = tick && (edge_q != LAST_EDGE) && !abort;
    lead      = !edge_q[0];
    sample_en = step && (cfg_cpha ? !lead : lead);
    shift_en  = step && (cfg_cpha ? (lead && edge_q != '0) : !lead);

    busy_d  = busy_q;
    edge_d  = edge_q;
    phase_d = phase_q;
    done_d  = done_q;
    rxb_d   = rxb_q;

    if (accept) begin
      busy_d  = 1'b1;
      edge_d  = '0;
      phase_d = 1'b0;
      done_d  = 1'b0;
    end else if (abort) begin
      busy_d  = 1'b0;
      phase_d = 1'b0;
    end else if (finish) begin
      busy_d  = 1'b0;
      done_d  = 1'b1;
      rxb_d   = rx_sh;
    end else if (step) begin
      edge_d  = edge_q + 1'b1;
      phase_d = !phase_q;
    end

    if (done_clr && !finish && !accept) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q  <= 1'b0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      rxb_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      edge_q  <= edge_d;
      phase_q <= phase_d;
      done_q  <= done_d;
      rxb_q   <= rxb_d;
    end
  end

  spim_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .lsb_first (cfg_lsb_first),
    .load      (accept),
    .load_data (tx_byte),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_sh)
  );

  assign sck     = phase_q ^ cfg_cpol;
  assign busy    = busy_q;
  assign ss_n    = !busy_q;
  assign done    = done_q;
  assign irq     = done_q && irq_en;
  assign rx_byte = rxb_q;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept |=> (busy && !ss_n));

  p_idle_sck_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> (sck == cfg_cpol));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !done_clr && !accept) |=> done);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !irq_en |-> !irq);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !enable) |=> (!busy && !done));
endmodule

// File: tb/spi_shift_master_test.sv
module spi_shift_master_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, enable, cfg_lsb_first, cfg_cpol, cfg_cpha, irq_en, start, done_clr;
  logic [1:0] cfg_rate;
  logic [7:0] tx_byte;
  logic miso = 1'b0;
  logic [7:0] rx_byte;
  logic done, irq, busy, sck, mosi, ss_n;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // slave model state
  logic [7:0] s_byte = 8'h00;
  logic [7:0] s_rx = 8'h00;
  int s_bit = 0, s_edges = 0, s_cyc = 0, cur_half = 2;
  int bad_period = 0, bad_mosi = 0;
  logic ss_prev = 1'b1, sck_prev = 1'b0, mosi_prev = 1'b0, lead_e, samp_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_master uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_lsb_first(cfg_lsb_first),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .irq_en(irq_en),
    .start(start), .tx_byte(tx_byte), .done_clr(done_clr), .miso(miso),
    .rx_byte(rx_byte), .done(done), .irq(irq), .busy(busy), .sck(sck),
    .mosi(mosi), .ss_n(ss_n)
  );

  function automatic logic sbit(input logic [7:0] b, input int j, input logic lsb);
    if (j > 7) return 1'b0;
    return lsb ? b[j] : b[7-j];
  endfunction

  function automatic int half_of(input logic [1:0] r);
    case (r)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  // slave reacting to SCK edges at the pins
  always @(negedge clk) begin
    if (ss_prev && !ss_n) begin
      s_bit = 0; s_edges = 0; s_rx = 8'h00; s_cyc = 0;
      bad_period = 0; bad_mosi = 0;
      if (!cfg_cpha) begin
        miso = sbit(s_byte, 0, cfg_lsb_first);
        s_bit = 1;
      end
    end else if (!ss_n) begin
      s_cyc = s_cyc + 1;
      if (sck !== sck_prev) begin
        lead_e = (sck !== cfg_cpol);
        samp_e = cfg_cpha ? !lead_e : lead_e;
        if (s_cyc != cur_half) bad_period = bad_period + 1;
        s_cyc = 0;
        s_edges = s_edges + 1;
        if (samp_e) begin
          if (mosi !== mosi_prev) bad_mosi = bad_mosi + 1;
          s_rx = cfg_lsb_first ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
        end else begin
          miso = sbit(s_byte, s_bit, cfg_lsb_first);
          s_bit = s_bit + 1;
        end
      end else if (mosi !== mosi_prev) begin
        bad_mosi = bad_mosi + 1;
      end
    end
    ss_prev = ss_n; sck_prev = sck; mosi_prev = mosi;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_xfer(input logic [7:0] t, input logic [7:0] s, input bit mid);
    int n;
    int h;
    h = half_of(cfg_rate);
    cur_half = h;
    s_byte = s;
    @(negedge clk);
    start = 1'b1; tx_byte = t;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", 32'(busy), 1);
    chk("R1 ss_n low", 32'(ss_n), 0);
    chk("R6 done cleared by start", 32'(done), 0);
    n = 0;
    while (busy === 1'b1 && n < 5000) begin
      n++;
      if (mid && n == 5) begin start = 1'b1; tx_byte = ~t; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(mid ? "R8 length with ignored start" : "R2 transfer length", 32'(n), 32'(17*h));
    chk("R3 rx_byte from miso", 32'(rx_byte), 32'(s));
    chk(mid ? "R8 slave got original byte" : "R4 R3 slave got tx byte in order", 32'(s_rx), 32'(t));
    chk("R2 edge count", 32'(s_edges), 16);
    chk("R2 half period", 32'(bad_period), 0);
    chk("R5 mosi change edge", 32'(bad_mosi), 0);
    chk("R6 done set", 32'(done), 1);
    chk("R7 irq gate", 32'(irq), 32'(irq_en));
    chk("R2 sck idle after", 32'(sck), 32'(cfg_cpol));
    chk("R1 ss_n released", 32'(ss_n), 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    int idx;
    rst_n = 1'b0; enable = 1'b1; cfg_lsb_first = 1'b0; cfg_cpol = 1'b1;
    cfg_cpha = 1'b0; cfg_rate = 2'd0; irq_en = 1'b0; start = 1'b0;
    tx_byte = 8'h00; done_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 ss_n", 32'(ss_n), 1);
    chk("R10 rx_byte", 32'(rx_byte), 0);
    chk("R10 sck idle high", 32'(sck), 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
    chk("R2 sck idle low", 32'(sck), 0);

    // sweep of divisor x polarity x phase x order x irq enable
    idx = 0;
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 8; m++) begin
        for (int k = 0; k < 2; k++) begin
          cfg_rate = 2'(r);
          cfg_cpol = m[0]; cfg_cpha = m[1]; cfg_lsb_first = m[2];
          irq_en = k[0];
          @(negedge clk);
          do_xfer(8'(8'hA5 ^ (idx * 37)), 8'(8'h3C + idx * 53), 1'b0);
          idx++;
        end
      end
    end

    // R6: clear input drops the flag
    irq_en = 1'b1;
    @(negedge clk);
    chk("R7 irq with done", 32'(irq), 1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R6 done_clr", 32'(done), 0);
    chk("R7 irq after clear", 32'(irq), 0);

    // R8: start during a transfer
    cfg_rate = 2'd1; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_lsb_first = 1'b1;
    do_xfer(8'h96, 8'h4B, 1'b1);
    cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    do_xfer(8'h01, 8'h80, 1'b1);

    // R9: abandon on enable low
    keep = rx_byte;
    cur_half = 8; s_byte = 8'hFF;
    @(negedge clk);
    start = 1'b1; tx_byte = 8'h55;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R9 abort busy", 32'(busy), 0);
    chk("R9 abort ss_n", 32'(ss_n), 1);
    chk("R9 abort sck idle", 32'(sck), 32'(cfg_cpol));
    chk("R9 abort done", 32'(done), 0);
    chk("R9 abort rx_byte kept", 32'(rx_byte), 32'(keep));

    // R9: start ignored while disabled
    start = 1'b1; tx_byte = 8'hC3;
    @(negedge clk);
    start = 1'b0;
    chk("R9 disabled start busy", 32'(busy), 0);
    chk("R9 disabled start ss_n", 32'(ss_n), 1);
    repeat (40) @(negedge clk);
    chk("R9 disabled no done", 32'(done), 0);
    chk("R9 disabled rx_byte", 32'(rx_byte), 32'(keep));
    enable = 1'b1;
    do_xfer(8'h3E, 8'hD1, 1'b0);

    finished = 1;
    summary();
    $finish;
  end
endmodule